// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Controller

This block decides, every cycle, where the operands of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) come from, and whether decode must wait. The pipeline has eight general registers and a three-bit negative/zero/positive condition code. The block receives the register specifiers and a few flags for the instructions in decode, execute, memory and writeback. From these it drives the select lines of the execute-stage ALU operand muxes, the memory-stage store-data mux and the condition-code source used by branch evaluation. It also drives a single decode stall.

When the forwarding mode input is high, results reach execute from the memory stage or the writeback stage, and store data reaches the memory stage from writeback. Condition codes are forwarded as well. The only remaining hazard is a load in execute whose result is needed at once. When the mode input is low, no forwarding path is used. Decode then waits until every producer it depends on has reached writeback. The register file writes in the first half of the cycle, so a producer in writeback never causes a wait.

A stall holds the program counter and the fetch/decode register and puts a bubble into execute. The datapath counts that bubble as a load-stall cycle. The block is purely combinational. The muxes, the register file and branch squashing are outside it.

Top module: `pipeFwdHazard`

## Requirements
- R1: With forwarding on, an ALU operand in execute whose use flag is set, and whose register is written by the memory-stage instruction, selects code 1 (memory stage). This holds even when writeback also writes that register.
- R2: With forwarding on, an ALU operand that matches only the writeback-stage destination selects code 2 (writeback). A producer with its register write enable low never matches, and then the operand selects code 0 (register file).
- R3: With forwarding on, the store-data select is 1 only when the memory-stage instruction is a store and its data register equals the writeback destination with the writeback write enable high. Otherwise the select is 0.
- R4: With forwarding on, a conditional branch in execute takes its condition code from code 1 when the memory stage writes the condition code. Otherwise it takes code 2 when writeback writes it, and otherwise code 0 (condition register). The select is 0 when execute holds no conditional branch.
- R5: With forwarding on, decode stalls when execute holds a load that writes a register read by decode. A non-load producer in execute causes no stall.
- R6: With forwarding on, a conditional branch in decode stalls behind a load in execute that writes the condition code.
- R7: With forwarding on, a store in decode whose only dependence on an execute-stage load is through its data operand (operand B) does not stall. A dependence through operand A does stall.
- R8: With forwarding off, every select (ALU A, ALU B, store data, condition code) is 0, whatever the matches.
- R9: With forwarding off, decode stalls when any used source register is written by execute or memory. It also stalls when a conditional branch in decode follows a condition-code writer in execute or memory. A producer in writeback alone causes no stall.
- R10: A decode source whose use flag is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwdEnable | input | 1 | Forwarding mode: 1 forwards, 0 stalls until writeback |
| dSrcA | input | 3 | Decode operand A register |
| dSrcAUse | input | 1 | Decode reads operand A |
| dSrcB | input | 3 | Decode operand B register (store data for stores) |
| dSrcBUse | input | 1 | Decode reads operand B |
| dIsStore | input | 1 | Decode holds a store |
| dUsesNzp | input | 1 | Decode holds a conditional branch |
| xSrcA | input | 3 | Execute operand A register |
| xSrcAUse | input | 1 | Execute reads operand A |
| xSrcB | input | 3 | Execute operand B register |
| xSrcBUse | input | 1 | Execute reads operand B |
| xUsesNzp | input | 1 | Execute holds a conditional branch |
| xDst | input | 3 | Execute destination register |
| xRegWe | input | 1 | Execute writes a register |
| xNzpWe | input | 1 | Execute writes the condition code |
| xIsLoad | input | 1 | Execute holds a load |
| mDst | input | 3 | Memory-stage destination register |
| mRegWe | input | 1 | Memory stage writes a register |
| mNzpWe | input | 1 | Memory stage writes the condition code |
| mIsStore | input | 1 | Memory stage holds a store |
| mStoreSrc | input | 3 | Data register of the memory-stage store |
| wDst | input | 3 | Writeback destination register |
| wRegWe | input | 1 | Writeback writes a register |
| wNzpWe | input | 1 | Writeback writes the condition code |
| aluASel | output | 2 | ALU A source: 0 register file, 1 memory, 2 writeback |
| aluBSel | output | 2 | ALU B source: same coding |
| storeDataSel | output | 1 | Store data: 0 pipeline value, 1 writeback value |
| nzpSel | output | 2 | Branch condition source: 0 register, 1 memory, 2 writeback |
| stallD | output | 1 | Hold PC and fetch/decode, bubble into execute |

## Verification
The bench makes memory and writeback match the same register at once. A design with the priority reversed would hand execute a stale value from writeback. It drives producers whose write enable is low. A design that compared registers without the enable would forward garbage or stall for nothing. It places a store behind a load, first with the dependence on the data operand and then on the address operand. This catches both a needless stall and a missed one. With the mode input low, it checks that writeback alone never stalls and that no select leaves zero.

// File: rtl/hzPkg.sv
package hzPkg;
  localparam int REG_AW = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic fwdOn;
    logic stall;
  } ctlStrobes_t;
endpackage

// File: rtl/hzMatch.sv
module hzMatch #(
  parameter int AW = 3
) (
  input  logic [AW-1:0] srcReg,
  input  logic          srcUse,
  input  logic [AW-1:0] dstReg,
  input  logic          dstWe,
  output logic          hit
);
  always_comb hit = srcUse && dstWe && (srcReg == dstReg);
endmodule

// File: rtl/hzStallCtl.sv
module hzStallCtl
  import hzPkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          fwdEnable,
  input  logic [AW-1:0] dSrcA,
  input  logic          dSrcAUse,
  input  logic [AW-1:0] dSrcB,
  input  logic          dSrcBUse,
  input  logic          dIsStore,
  input  logic          dUsesNzp,
  input  logic [AW-1:0] xDst,
  input  logic          xRegWe,
  input  logic          xNzpWe,
  input  logic          xIsLoad,
  input  logic [AW-1:0] mDst,
  input  logic          mRegWe,
  input  logic          mNzpWe,
  output ctlStrobes_t   strobes
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][AW-1:0] srcReg;
  logic [N_OPS-1:0]         srcUse;
  logic [N_OPS-1:0]         hitX;
  logic [N_OPS-1:0]         hitM;

  always_comb begin
    srcReg[0] = dSrcA;
    srcReg[1] = dSrcB;
    srcUse[0] = dSrcAUse;
    srcUse[1] = dSrcBUse;
  end

  for (genvar op = 0; op < N_OPS; op++) begin : gOpCmp
    hzMatch #(.AW(AW)) uCmpX (
      .srcReg(srcReg[op]), .srcUse(srcUse[op]),
      .dstReg(xDst), .dstWe(xRegWe), .hit(hitX[op])
    );
    hzMatch #(.AW(AW)) uCmpM (
      .srcReg(srcReg[op]), .srcUse(srcUse[op]),
      .dstReg(mDst), .dstWe(mRegWe), .hit(hitM[op])
    );
  end

  logic loadUseA;
  logic loadUseB;
  logic loadNzp;
  logic stallFwd;
  logic stallNoFwd;

  always_comb begin
    // operand B of a store is data; it is covered later by the W->M path
    loadUseA   = xIsLoad && hitX[0];
    loadUseB   = xIsLoad && hitX[1] && !dIsStore;
    loadNzp    = xIsLoad && xNzpWe && dUsesNzp;
    stallFwd   = loadUseA || loadUseB || loadNzp;
    stallNoFwd = (|hitX) || (|hitM) || (dUsesNzp && (xNzpWe || mNzpWe));
    strobes.fwdOn = fwdEnable;
    strobes.stall = fwdEnable ? stallFwd : stallNoFwd;
  end
endmodule

// File: rtl/hzFwdSelect.sv
module hzFwdSelect
  import hzPkg::*;
#(
  parameter int AW = REG_AW
) (
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] xSrcA,
  input  logic          xSrcAUse,
  input  logic [AW-1:0] xSrcB,
  input  logic          xSrcBUse,
  input  logic          xUsesNzp,
  input  logic [AW-1:0] mDst,
  input  logic          mRegWe,
  input  logic          mNzpWe,
  input  logic          mIsStore,
  input  logic [AW-1:0] mStoreSrc,
  input  logic [AW-1:0] wDst,
  input  logic          wRegWe,
  input  logic          wNzpWe,
  output logic [SEL_W-1:0] aluASel,
  output logic [SEL_W-1:0] aluBSel,
  output logic             storeDataSel,
  output logic [SEL_W-1:0] nzpSel
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][AW-1:0]    opReg;
  logic [N_OPS-1:0]            opUse;
  logic [N_OPS-1:0]            hitM;
  logic [N_OPS-1:0]            hitW;
  logic [N_OPS-1:0][SEL_W-1:0] opSel;
  logic                        storeHitW;

  always_comb begin
    opReg[0] = xSrcA;
    opReg[1] = xSrcB;
    opUse[0] = xSrcAUse;
    opUse[1] = xSrcBUse;
  end

  for (genvar op = 0; op < N_OPS; op++) begin : gOpFwd
    hzMatch #(.AW(AW)) uCmpM (
      .srcReg(opReg[op]), .srcUse(opUse[op]),
      .dstReg(mDst), .dstWe(mRegWe), .hit(hitM[op])
    );
    hzMatch #(.AW(AW)) uCmpW (
      .srcReg(opReg[op]), .srcUse(opUse[op]),
      .dstReg(wDst), .dstWe(wRegWe), .hit(hitW[op])
    );
    always_comb begin
      if (!strobes.fwdOn)   opSel[op] = SRC_RF;
      else if (hitM[op])    opSel[op] = SRC_MEM;
      else if (hitW[op])    opSel[op] = SRC_WB;
      else                  opSel[op] = SRC_RF;
    end
  end

  hzMatch #(.AW(AW)) uCmpStore (
    .srcReg(mStoreSrc), .srcUse(mIsStore),
    .dstReg(wDst), .dstWe(wRegWe), .hit(storeHitW)
  );

  always_comb begin
    aluASel      = opSel[0];
    aluBSel      = opSel[1];
    storeDataSel = strobes.fwdOn && storeHitW;
    if (!strobes.fwdOn || !xUsesNzp) nzpSel = SRC_RF;
    else if (mNzpWe)                 nzpSel = SRC_MEM;
    else if (wNzpWe)                 nzpSel = SRC_WB;
    else                             nzpSel = SRC_RF;
  end
endmodule

// File: rtl/pipeFwdHazard.sv
module pipeFwdHazard
  import hzPkg::*;
(
  input  logic       fwdEnable,
  input  logic [2:0] dSrcA,
  input  logic       dSrcAUse,
  input  logic [2:0] dSrcB,
  input  logic       dSrcBUse,
  input  logic       dIsStore,
  input  logic       dUsesNzp,
  input  logic [2:0] xSrcA,
  input  logic       xSrcAUse,
  input  logic [2:0] xSrcB,
  input  logic       xSrcBUse,
  input  logic       xUsesNzp,
  input  logic [2:0] xDst,
  input  logic       xRegWe,
  input  logic       xNzpWe,
  input  logic       xIsLoad,
  input  logic [2:0] mDst,
  input  logic       mRegWe,
  input  logic       mNzpWe,
  input  logic       mIsStore,
  input  logic [2:0] mStoreSrc,
  input  logic [2:0] wDst,
  input  logic       wRegWe,
  input  logic       wNzpWe,
  output logic [1:0] aluASel,
  output logic [1:0] aluBSel,
  output logic       storeDataSel,
  output logic [1:0] nzpSel,
  output logic       stallD
);
  ctlStrobes_t strobes;

  hzStallCtl #(.AW(REG_AW)) uCtl (
    .fwdEnable(fwdEnable),
    .dSrcA(dSrcA), .dSrcAUse(dSrcAUse),
    .dSrcB(dSrcB), .dSrcBUse(dSrcBUse),
    .dIsStore(dIsStore), .dUsesNzp(dUsesNzp),
    .xDst(xDst), .xRegWe(xRegWe), .xNzpWe(xNzpWe), .xIsLoad(xIsLoad),
    .mDst(mDst), .mRegWe(mRegWe), .mNzpWe(mNzpWe),
    .strobes(strobes)
  );

  hzFwdSelect #(.AW(REG_AW)) uDp (
    .strobes(strobes),
    .xSrcA(xSrcA), .xSrcAUse(xSrcAUse),
    .xSrcB(xSrcB), .xSrcBUse(xSrcBUse),
    .xUsesNzp(xUsesNzp),
    .mDst(mDst), .mRegWe(mRegWe), .mNzpWe(mNzpWe),
    .mIsStore(mIsStore), .mStoreSrc(mStoreSrc),
    .wDst(wDst), .wRegWe(wRegWe), .wNzpWe(wNzpWe),
    .aluASel(aluASel), .aluBSel(aluBSel),
    .storeDataSel(storeDataSel), .nzpSel(nzpSel)
  );

  always_comb stallD = strobes.stall;
endmodule

// File: rtl/pipeFwdHazardChk.sv
module pipeFwdHazardChk (
  input logic       fwdEnable,
  input logic [2:0] xSrcA,
  input logic       xSrcAUse,
  input logic       xUsesNzp,
  input logic       xIsLoad,
  input logic [2:0] mDst,
  input logic       mRegWe,
  input logic       mNzpWe,
  input logic       mIsStore,
  input logic       wRegWe,
  input logic       wNzpWe,
  input logic       dSrcAUse,
  input logic       dSrcBUse,
  input logic       dUsesNzp,
  input logic [1:0] aluASel,
  input logic [1:0] aluBSel,
  input logic       storeDataSel,
  input logic [1:0] nzpSel,
  input logic       stallD
);
  always_comb begin
    // R1: a memory-stage pick needs a live matching writer there
    assert_mem_pick_valid_R1: assert (aluASel != 2'd1 || (mRegWe && xSrcAUse && mDst == xSrcA));
    // R2: no select code beyond writeback
    assert_sel_code_range_R2: assert (aluASel != 2'd3 && aluBSel != 2'd3);
    // R2: a writeback pick needs a writing writeback stage
    assert_wb_pick_we_R2: assert (aluBSel != 2'd2 || wRegWe);
    // R3: store data forwarded only into a store with a writer behind it
    assert_store_fwd_R3: assert (!storeDataSel || (mIsStore && wRegWe));
    // R4: condition source matches an actual writer
    assert_nzp_src_R4: assert ((nzpSel != 2'd1 || (mNzpWe && xUsesNzp)) && (nzpSel != 2'd2 || (wNzpWe && !mNzpWe)) && nzpSel != 2'd3);
    // R5: with forwarding, only a load in execute can stall
    assert_stall_load_only_R5: assert (!(fwdEnable && stallD) || xIsLoad);
    // R8: forwarding off leaves every mux on its default
    assert_no_fwd_when_off_R8: assert (fwdEnable || (aluASel == 2'd0 && aluBSel == 2'd0 && !storeDataSel && nzpSel == 2'd0));
    // R10: nothing used in decode, nothing to wait for
    assert_idle_no_stall_R10: assert (dSrcAUse || dSrcBUse || dUsesNzp || !stallD);
  end
endmodule

bind pipeFwdHazard pipeFwdHazardChk chk (
  .fwdEnable(fwdEnable), .xSrcA(xSrcA), .xSrcAUse(xSrcAUse),
  .xUsesNzp(xUsesNzp), .xIsLoad(xIsLoad), .mDst(mDst), .mRegWe(mRegWe),
  .mNzpWe(mNzpWe), .mIsStore(mIsStore), .wRegWe(wRegWe), .wNzpWe(wNzpWe),
  .dSrcAUse(dSrcAUse), .dSrcBUse(dSrcBUse), .dUsesNzp(dUsesNzp),
  .aluASel(aluASel), .aluBSel(aluBSel), .storeDataSel(storeDataSel),
  .nzpSel(nzpSel), .stallD(stallD)
);

// File: tb/pipeFwdHazard_test.sv
module pipeFwdHazard_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  int checks = 0;
  int errors = 0;

  logic       fwdEnable;
  logic [2:0] dSrcA, dSrcB, xSrcA, xSrcB, xDst, mDst, mStoreSrc, wDst;
  logic dSrcAUse, dSrcBUse, dIsStore, dUsesNzp;
  logic xSrcAUse, xSrcBUse, xUsesNzp, xRegWe, xNzpWe, xIsLoad;
  logic mRegWe, mNzpWe, mIsStore, wRegWe, wNzpWe;
  logic [1:0] aluASel, aluBSel, nzpSel;
  logic storeDataSel, stallD;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipeFwdHazard uut (
    .fwdEnable(fwdEnable),
    .dSrcA(dSrcA), .dSrcAUse(dSrcAUse), .dSrcB(dSrcB), .dSrcBUse(dSrcBUse),
    .dIsStore(dIsStore), .dUsesNzp(dUsesNzp),
    .xSrcA(xSrcA), .xSrcAUse(xSrcAUse), .xSrcB(xSrcB), .xSrcBUse(xSrcBUse),
    .xUsesNzp(xUsesNzp), .xDst(xDst), .xRegWe(xRegWe), .xNzpWe(xNzpWe),
    .xIsLoad(xIsLoad),
    .mDst(mDst), .mRegWe(mRegWe), .mNzpWe(mNzpWe), .mIsStore(mIsStore),
    .mStoreSrc(mStoreSrc),
    .wDst(wDst), .wRegWe(wRegWe), .wNzpWe(wNzpWe),
    .aluASel(aluASel), .aluBSel(aluBSel), .storeDataSel(storeDataSel),
    .nzpSel(nzpSel), .stallD(stallD)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clearAll(input logic fwd);
    @(negedge clk);
    fwdEnable = fwd;
    dSrcA = 3'd0; dSrcB = 3'd0; xSrcA = 3'd0; xSrcB = 3'd0;
    xDst = 3'd0; mDst = 3'd0; mStoreSrc = 3'd0; wDst = 3'd0;
    dSrcAUse = 0; dSrcBUse = 0; dIsStore = 0; dUsesNzp = 0;
    xSrcAUse = 0; xSrcBUse = 0; xUsesNzp = 0; xRegWe = 0; xNzpWe = 0;
    xIsLoad = 0; mRegWe = 0; mNzpWe = 0; mIsStore = 0; wRegWe = 0; wNzpWe = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic testIdle();
    clearAll(1'b1); settle();
    chk("R10 idle stall", stallD, 0);
    chk("R2 idle aluA", aluASel, 0);
    chk("R4 idle nzp", nzpSel, 0);
  endtask

  task automatic testAluFwd();
    clearAll(1'b1);
    xSrcA = 3'd3; xSrcAUse = 1; mDst = 3'd3; mRegWe = 1; wDst = 3'd3; wRegWe = 1;
    xSrcB = 3'd5; xSrcBUse = 1;
    settle();
    chk("R1 mem over wb aluA", aluASel, 1);
    chk("R2 no match aluB", aluBSel, 0);
    xSrcB = 3'd3; settle();
    chk("R1 mem pick aluB", aluBSel, 1);
    mRegWe = 0; settle();
    chk("R2 wb pick when mem we low", aluASel, 2);
    wRegWe = 0; settle();
    chk("R2 both we low", aluASel, 0);
    wRegWe = 1; xSrcAUse = 0; settle();
    chk("R2 unused operand", aluASel, 0);
  endtask

  task automatic testStoreFwd();
    clearAll(1'b1);
    mIsStore = 1; mStoreSrc = 3'd4; wDst = 3'd4; wRegWe = 1; settle();
    chk("R3 store wb fwd", storeDataSel, 1);
    wDst = 3'd2; settle();
    chk("R3 store reg mismatch", storeDataSel, 0);
    wDst = 3'd4; mIsStore = 0; settle();
    chk("R3 not a store", storeDataSel, 0);
    mIsStore = 1; wRegWe = 0; settle();
    chk("R3 wb we low", storeDataSel, 0);
  endtask

  task automatic testNzpFwd();
    clearAll(1'b1);
    xUsesNzp = 1; mNzpWe = 1; wNzpWe = 1; settle();
    chk("R4 nzp mem over wb", nzpSel, 1);
    mNzpWe = 0; settle();
    chk("R4 nzp wb", nzpSel, 2);
    xUsesNzp = 0; settle();
    chk("R4 no branch", nzpSel, 0);
  endtask

  task automatic testLoadUse();
    clearAll(1'b1);
    xIsLoad = 1; xRegWe = 1; xDst = 3'd2; dSrcA = 3'd2; dSrcAUse = 1; settle();
    chk("R5 load use stall", stallD, 1);
    xIsLoad = 0; settle();
    chk("R5 alu producer no stall", stallD, 0);
    dSrcA = 3'd6; xIsLoad = 1; settle();
    chk("R5 load other reg", stallD, 0);
    dSrcAUse = 0; dUsesNzp = 1; xNzpWe = 1; settle();
    chk("R6 load to branch stall", stallD, 1);
    xIsLoad = 0; settle();
    chk("R6 alu to branch no stall", stallD, 0);
  endtask

  task automatic testStoreAfterLoad();
    clearAll(1'b1);
    xIsLoad = 1; xRegWe = 1; xDst = 3'd2;
    dIsStore = 1; dSrcB = 3'd2; dSrcBUse = 1; dSrcA = 3'd7; dSrcAUse = 1; settle();
    chk("R7 store data only no stall", stallD, 0);
    dSrcA = 3'd2; settle();
    chk("R7 store address stall", stallD, 1);
    dSrcA = 3'd7; dIsStore = 0; settle();
    chk("R5 non-store operand B stall", stallD, 1);
  endtask

  task automatic testNoFwd();
    clearAll(1'b0);
    xSrcA = 3'd3; xSrcAUse = 1; mDst = 3'd3; mRegWe = 1;
    xSrcB = 3'd4; xSrcBUse = 1; wDst = 3'd4; wRegWe = 1;
    mIsStore = 1; mStoreSrc = 3'd4; xUsesNzp = 1; mNzpWe = 1; settle();
    chk("R8 aluA off", aluASel, 0);
    chk("R8 aluB off", aluBSel, 0);
    chk("R8 store off", storeDataSel, 0);
    chk("R8 nzp off", nzpSel, 0);
    clearAll(1'b0);
    dSrcA = 3'd1; dSrcAUse = 1; xDst = 3'd1; xRegWe = 1; settle();
    chk("R9 x producer stall", stallD, 1);
    xRegWe = 0; mDst = 3'd1; mRegWe = 1; settle();
    chk("R9 m producer stall", stallD, 1);
    mRegWe = 0; wDst = 3'd1; wRegWe = 1; settle();
    chk("R9 wb producer no stall", stallD, 0);
    dSrcAUse = 0; dUsesNzp = 1; mNzpWe = 1; settle();
    chk("R9 nzp m stall", stallD, 1);
    mNzpWe = 0; wNzpWe = 1; settle();
    chk("R9 nzp wb no stall", stallD, 0);
  endtask

  task automatic testUnused();
    clearAll(1'b0);
    dSrcA = 3'd5; dSrcB = 3'd5; xDst = 3'd5; xRegWe = 1; mDst = 3'd5; mRegWe = 1;
    xNzpWe = 1; settle();
    chk("R10 unused off mode", stallD, 0);
    fwdEnable = 1; xIsLoad = 1; settle();
    chk("R10 unused fwd mode", stallD, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    testIdle();
    testAluFwd();
    testStoreFwd();
    testNzpFwd();
    testLoadUse();
    testStoreAfterLoad();
    testNoFwd();
    testUnused();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule